// File: doc/BRIEF.md
# I2C SCL Phase Generator

This block produces the serial clock of an I2C master from the peripheral clock. Two programmable 16-bit counts set the length of the two halves of each SCL period, both in peripheral-clock cycles. One sets how long the block drives the line low. The other sets how long the line stays released and high. With no device stretching the clock, the SCL bit rate is the peripheral clock frequency divided by the sum of the two counts. For example, counts of 100 and 100 on a 20 MHz clock give a 100 kHz clock with a 50% duty cycle.

The line is open drain, so the block only asserts a pull-low request. It also watches the sampled line level. The high half is timed only from the moment the released line actually reads high, so a slave that holds SCL low stretches the clock. If another master pulls the line low while this block is in its high half, the block starts its low half at once, which keeps the clocks in step. One-cycle pulses mark the start of each high half and each low half, for the byte-level sequencer that drives SDA.

The count registers reset to 4. A written value below 4 is raised to 4. A new value takes effect only when the next phase of that kind begins.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset both counts are 4, `scl_pull` is 0 and both pulses are 0; enabling without any write gives an SCL period of 8 cycles.
- R2: Each low phase asserts `scl_pull` for exactly the low count of consecutive cycles.
- R3: The released-high time equals the high count when the line is not held low, so the full period is the high count plus the low count.
- R4: A value below 4 written to either count is used as 4.
- R5: A count written during a phase does not change the phase in progress; it is used from the next phase of that kind.
- R6: After the release, the high count does not start while the sampled line reads low. `rise_pulse` appears in the cycle after the line is first seen high.
- R7: If the sampled line reads low during the high phase, the next cycle starts a low phase: `fall_pulse` is 1 and `scl_pull` is 1.
- R8: While `en` is 0, from the cycle after it drops, `scl_pull`, `rise_pulse` and `fall_pulse` are 0. Re-enabling starts a low phase in the next cycle.
- R9: `fall_pulse` is high for one cycle at the first cycle of each low phase. `rise_pulse` is high for one cycle at the first cycle of each counted high phase. The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables SCL generation |
| hi_val | input | 16 | High-phase count to write |
| hi_wr | input | 1 | Write strobe for the high count |
| lo_val | input | 16 | Low-phase count to write |
| lo_wr | input | 1 | Write strobe for the low count |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull | output | 1 | 1 requests the open-drain driver to pull SCL low |
| rise_pulse | output | 1 | One-cycle pulse at the start of the high phase |
| fall_pulse | output | 1 | One-cycle pulse at the start of the low phase |

## Verification
A wrong phase counter or a wrong stored count shows up in the length of the next low run of `scl_pull`, or in when the next edge pulse arrives. So the error is visible within one SCL period. A state machine that ignores the sampled line shows up in the same cycle that stretching or synchronization is applied: the edge pulse comes early or not at all. Comparing the three outputs on every cycle against a reference model catches such an error in the first cycle where it changes the output.

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int CW = 16,
  parameter int MIN_CNT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] hi_val,
  input  logic          hi_wr,
  input  logic [CW-1:0] lo_val,
  input  logic          lo_wr,
  input  logic          scl_in,
  output logic          scl_pull,
  output logic          rise_pulse,
  output logic          fall_pulse
);

  localparam logic [CW-1:0] FLOOR = CW'(MIN_CNT);
  localparam logic [CW-1:0] ONE   = CW'(1);

  typedef enum logic [1:0] {S_OFF, S_LOW, S_WAIT, S_HIGH} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] hi_reg, lo_reg;

  function automatic logic [CW-1:0] floor4(input logic [CW-1:0] v);
    return (v < FLOOR) ? FLOOR : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_reg <= FLOOR;
      lo_reg <= FLOOR;
    end else begin
      if (hi_wr) hi_reg <= floor4(hi_val);
      if (lo_wr) lo_reg <= floor4(lo_val);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_OFF;
      cnt        <= '0;
      rise_pulse <= 1'b0;
      fall_pulse <= 1'b0;
    end else begin
      rise_pulse <= 1'b0;
      fall_pulse <= 1'b0;
      if (!en) begin
        st  <= S_OFF;
        cnt <= '0;
      end else begin
        unique case (st)
          S_OFF: begin
            st         <= S_LOW;
            cnt        <= lo_reg;
            fall_pulse <= 1'b1;
          end
          S_LOW: begin
            if (cnt == ONE) begin
              st  <= S_WAIT;
              cnt <= '0;
            end else begin
              cnt <= cnt - ONE;
            end
          end
          S_WAIT: begin
            if (scl_in) begin
              st         <= S_HIGH;
              cnt        <= hi_reg - ONE;
              rise_pulse <= 1'b1;
            end
          end
          S_HIGH: begin
            if (!scl_in || cnt == ONE) begin
              st         <= S_LOW;
              cnt        <= lo_reg;
              fall_pulse <= 1'b1;
            end else begin
              cnt <= cnt - ONE;
            end
          end
          default: begin
            st  <= S_OFF;
            cnt <= '0;
          end
        endcase
      end
    end
  end

  assign scl_pull = (st == S_LOW);

  a_r4_hi_floor: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> hi_reg >= FLOOR);
  a_r4_lo_floor: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> lo_reg >= FLOOR);
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull && !rise_pulse && !fall_pulse));
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_pulse && fall_pulse));
  a_r9_fall_drives: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |-> scl_pull);
  a_r6_rise_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |-> ($past(scl_in) && !scl_pull));
  a_r7_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_HIGH && !scl_in) |=> fall_pulse);
  a_r2_low_counting: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> cnt != '0);

endmodule

// File: tb/scl_phase_gen_bench.sv
module scl_phase_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] hi_val = '0, lo_val = '0;
  logic        hi_wr = 1'b0, lo_wr = 1'b0;
  logic        ext_low = 1'b0;
  logic        scl_in;
  logic        scl_pull, rise_pulse, fall_pulse;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign scl_in = !scl_pull && !ext_low;

  scl_phase_gen u_scl_phase_gen (
    .clk(clk), .rst_n(rst_n), .en(en),
    .hi_val(hi_val), .hi_wr(hi_wr), .lo_val(lo_val), .lo_wr(lo_wr),
    .scl_in(scl_in), .scl_pull(scl_pull),
    .rise_pulse(rise_pulse), .fall_pulse(fall_pulse));

  // behavioural reference: 0 off, 1 low, 2 waiting for line high, 3 high
  int m_st = 0, m_cnt = 0, m_hi = 4, m_lo = 4;
  bit m_pull = 0, m_rise = 0, m_fall = 0;

  function automatic int floor4(input int v);
    return (v < 4) ? 4 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_hi = 4; m_lo = 4;
      m_rise = 0; m_fall = 0; m_pull = 0;
    end else begin
      bit line;
      line = !m_pull && !ext_low;
      m_rise = 0; m_fall = 0;
      if (!en) begin
        m_st = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        m_st = 1; m_cnt = m_lo; m_fall = 1;
      end else if (m_st == 1) begin
        if (m_cnt == 1) begin m_st = 2; m_cnt = 0; end
        else m_cnt--;
      end else if (m_st == 2) begin
        if (line) begin m_st = 3; m_cnt = m_hi - 1; m_rise = 1; end
      end else begin
        if (!line || m_cnt == 1) begin m_st = 1; m_cnt = m_lo; m_fall = 1; end
        else m_cnt--;
      end
      if (hi_wr) m_hi = floor4(int'(hi_val));
      if (lo_wr) m_lo = floor4(int'(lo_val));
      m_pull = (m_st == 1);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(scl_pull == m_pull, "R2 scl_pull model", scl_pull, m_pull);
      check(rise_pulse == m_rise, "R9 rise_pulse model", rise_pulse, m_rise);
      check(fall_pulse == m_fall, "R9 fall_pulse model", fall_pulse, m_fall);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_fall();
    while (!fall_pulse) @(negedge clk);
  endtask

  task automatic meas_period(output int n);
    wait_fall();
    n = 0;
    do begin @(negedge clk); n++; end while (!fall_pulse);
  endtask

  task automatic meas_low(output int n);
    wait_fall();
    n = 0;
    while (scl_pull) begin n++; @(negedge clk); end
  endtask

  task automatic write_counts(input int h, input int l);
    @(negedge clk);
    hi_val = 16'(h); lo_val = 16'(l); hi_wr = 1; lo_wr = 1;
    @(negedge clk);
    hi_wr = 0; lo_wr = 0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset
    check(!scl_pull && !rise_pulse && !fall_pulse, "R1 reset outputs",
          {scl_pull, rise_pulse, fall_pulse}, 0);
    rst_n = 1;
    @(negedge clk);
    en = 1;
    meas_period(n);
    check(n == 8, "R1 default period", n, 8);

    // R3 / R2: period and low length
    write_counts(5, 7);
    meas_period(n);
    meas_period(n);
    check(n == 12, "R3 period hi+lo", n, 12);
    meas_low(n);
    check(n == 7, "R2 low length", n, 7);

    // R4: clamp
    write_counts(1, 0);
    meas_period(n);
    meas_period(n);
    check(n == 8, "R4 clamp period", n, 8);
    meas_low(n);
    check(n == 4, "R4 clamp low", n, 4);

    // R5: write mid-phase
    write_counts(6, 10);
    meas_period(n);
    wait_fall();
    lo_val = 16'd5; lo_wr = 1;
    n = 0;
    @(negedge clk); lo_wr = 0; n = 1;
    while (scl_pull) begin n++; @(negedge clk); end
    check(n == 10, "R5 old low kept", n, 10);
    meas_low(n);
    check(n == 5, "R5 new low used", n, 5);

    // R6: stretching
    wait_fall();
    ext_low = 1;
    while (scl_pull) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check(!rise_pulse, "R6 no rise while held", rise_pulse, 0);
      @(negedge clk);
    end
    ext_low = 0;
    @(negedge clk);
    check(rise_pulse == 1, "R6 rise after release", rise_pulse, 1);

    // R7: synchronization
    @(negedge clk);
    ext_low = 1;
    @(negedge clk);
    ext_low = 0;
    check(fall_pulse && scl_pull, "R7 restart low", {fall_pulse, scl_pull}, 3);

    // R8: disable
    repeat (3) @(negedge clk);
    en = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check(!scl_pull && !rise_pulse && !fall_pulse, "R8 disabled quiet",
            {scl_pull, rise_pulse, fall_pulse}, 0);
      @(negedge clk);
    end
    en = 1;
    @(negedge clk);
    check(fall_pulse && scl_pull, "R8 restart", {fall_pulse, scl_pull}, 3);

    // R9 and model tracking over a few more periods
    write_counts(9, 4);
    repeat (60) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule